// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost Flags

A first-in first-out buffer for 9-bit words that sits between two unrelated clock domains. The producer pushes words with its own write clock, and the consumer pops them with its own read clock. Each pointer crosses into the other domain as Gray code through a two-stage synchroniser. Each domain has its own pair of flags. The read side owns empty and almost-empty, and the write side owns full and almost-full. All flags are active low and registered, so each one changes only on the clock of the domain that owns it. A flag that announces free space or available data can therefore come a few cycles late. A flag that blocks an access can never come late.

Writes use two enables: an active-low primary enable and an active-high secondary pin. Reads use two active-low enables. The secondary write pin has two roles, and the level it holds while reset is asserted fixes its role until the next reset. When it is held high during reset, it is only a second write enable. When it is held low during reset, it also serves as a load select for threshold access that is held outside this block. While that pin is low, the FIFO itself neither pushes nor pops. The almost-empty threshold n and the almost-full threshold m arrive as input ports, and the recommended tie-off for both is 7. Read data comes from a registered output that changes only on a successful read. The output-enable input is mirrored to a plain control output.

Top module: `dc_prog_fifo`

## Requirements
- R1: A word is stored on a rising write-clock edge only when `wen1_ni` is 0, `wen2_ld_i` is 1 and `full_no` is 1. A write attempt while full is dropped, and the stored contents do not change.
- R2: A word is removed on a rising read-clock edge only when `ren1_ni` and `ren2_ni` are both 0 and `empty_no` is 1. On that edge `data_o` takes the oldest stored word. A read attempt while empty leaves `data_o` holding the last word that was read.
- R3: The block samples `wen2_ld_i` while `rst_ni` is 0. If the sampled value is 0 (load mode), reads are ignored while `wen2_ld_i` is 0. If the sampled value is 1 (two-enable mode), `wen2_ld_i` has no effect on reads. In both modes `wen2_ld_i` = 0 blocks writes.
- R4: Once the domains have settled, `empty_no` is 0 exactly when the FIFO holds no words, and it is updated only by the read clock.
- R5: Once the domains have settled, `full_no` is 0 exactly when the FIFO holds DEPTH words, and it is updated only by the write clock.
- R6: Once the domains have settled, `almost_empty_no` is 1 exactly when the word count is greater than `ae_thr_i` (n). It is 0 at n or fewer words.
- R7: Once the domains have settled, `almost_full_no` is 1 exactly when the free locations number more than `af_thr_i` (m). It is 0 when the count is DEPTH−m or more.
- R8: After reset the FIFO is empty. In that state `empty_no` = 0, `almost_empty_no` = 0, `full_no` = 1, `almost_full_no` = 1 and `data_o` = 0.
- R9: Words leave in the order in which they were written, with no loss and no duplication, when both clocks run continuously at unrelated rates.
- R10: When the first word is written into an empty FIFO, it does not appear on `data_o` when `empty_no` rises. It appears only after the first read edge that follows.
- R11: `data_oe_o` equals the inverse of `oe_ni`, with no clock involved.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk_i | input | 1 | Write clock |
| rclk_i | input | 1 | Read clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wen1_ni | input | 1 | Primary write enable, active low |
| wen2_ld_i | input | 1 | Secondary write enable; role latched during reset |
| data_i | input | DW | Write data |
| ren1_ni | input | 1 | Read enable one, active low |
| ren2_ni | input | 1 | Read enable two, active low |
| oe_ni | input | 1 | Output enable request, active low |
| ae_thr_i | input | AW | Almost-empty threshold n |
| af_thr_i | input | AW | Almost-full threshold m |
| data_o | output | DW | Registered read data |
| data_oe_o | output | 1 | Output enable control, active high |
| empty_no | output | 1 | 0 when empty (read domain) |
| full_no | output | 1 | 0 when full (write domain) |
| almost_empty_no | output | 1 | 0 when count ≤ n (read domain) |
| almost_full_no | output | 1 | 0 when free ≤ m (write domain) |

## Verification
The bench sweeps the word count through every value from empty to full for several threshold pairs, including n = m = 0 and n = m = DEPTH−1. An off-by-one in a threshold comparison would therefore move a flag edge by one word, and the sweep would catch it. It tries to write past full and to read past empty, then drains the FIFO. A design that let the extra write through would return an extra word, and one that let the extra read through would change `data_o`. It resets in each pin mode and issues accesses with the secondary pin low. A mode latch that was wrong or inverted would pop a word while the pin is low, or would ignore a valid read. A streaming run at two unrelated clock rates would show broken Gray crossing as reordered, lost or repeated words.

// File: rtl/dcpf_pkg.sv
package dcpf_pkg;
  typedef enum logic {
    MODE_TWO_EN = 1'b0,
    MODE_LOAD   = 1'b1
  } pin_mode_e;
endpackage

// File: rtl/dcpf_sync.sv
module dcpf_sync #(
  parameter int W = 5
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] s1_q, s2_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q <= '0;
      s2_q <= '0;
    end else begin
      s1_q <= d_i;
      s2_q <= s1_q;
    end
  end
  assign q_o = s2_q;
endmodule

// File: rtl/dcpf_mem.sv
module dcpf_mem #(
  parameter int DW = 9,
  parameter int AW = 4
) (
  input  logic          wclk_i,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem_q [DEPTH];
  always_ff @(posedge wclk_i) begin
    if (we_i) mem_q[waddr_i] <= wdata_i;
  end
  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/dcpf_wr_ctl.sv
module dcpf_wr_ctl #(
  parameter int AW = 4
) (
  input  logic          wclk_i,
  input  logic          rst_ni,
  input  logic          wen1_ni,
  input  logic          wen2_i,
  input  logic [AW:0]   rgray_s_i,
  input  logic [AW-1:0] af_thr_i,
  output logic          we_o,
  output logic [AW-1:0] waddr_o,
  output logic [AW:0]   wgray_o,
  output logic          full_no,
  output logic          almost_full_no
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  logic [PW-1:0] wbin_q, wbin_n, wgray_q, rbin_s, used_n, free_n;
  logic          wr_en;

  assign wr_en  = !wen1_ni && wen2_i && full_no;
  assign wbin_n = wbin_q + PW'(wr_en);
  assign rbin_s = g2b(rgray_s_i);
  assign used_n = wbin_n - rbin_s;
  assign free_n = PW'(DEPTH) - used_n;

  always_ff @(posedge wclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wbin_q         <= '0;
      wgray_q        <= '0;
      full_no        <= 1'b1;
      almost_full_no <= 1'b1;
    end else begin
      wbin_q         <= wbin_n;
      wgray_q        <= wbin_n ^ (wbin_n >> 1);
      full_no        <= (used_n != PW'(DEPTH));
      almost_full_no <= (free_n > {1'b0, af_thr_i});
    end
  end

  assign we_o    = wr_en;
  assign waddr_o = wbin_q[AW-1:0];
  assign wgray_o = wgray_q;

  // R5
  wr_occupancy_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    (wbin_q - rbin_s) <= PW'(DEPTH));
  // R7
  full_forces_af_chk: assert property (@(posedge wclk_i) disable iff (!rst_ni)
    !full_no |-> !almost_full_no);
endmodule

// File: rtl/dcpf_rd_ctl.sv
module dcpf_rd_ctl
  import dcpf_pkg::*;
#(
  parameter int DW = 9,
  parameter int AW = 4
) (
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          ren1_ni,
  input  logic          ren2_ni,
  input  logic          ld_i,
  input  logic [AW:0]   wgray_s_i,
  input  logic [AW-1:0] ae_thr_i,
  input  logic [DW-1:0] mem_data_i,
  output logic [AW-1:0] raddr_o,
  output logic [AW:0]   rgray_o,
  output logic [DW-1:0] data_o,
  output logic          empty_no,
  output logic          almost_empty_no
);
  localparam int PW    = AW + 1;
  localparam int DEPTH = 1 << AW;

  function automatic logic [PW-1:0] g2b(input logic [PW-1:0] g);
    logic [PW-1:0] b;
    b[PW-1] = g[PW-1];
    for (int i = PW - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  pin_mode_e     mode_q;
  logic [PW-1:0] rbin_q, rbin_n, rgray_q, wbin_s, cnt_n;
  logic [DW-1:0] data_q;
  logic          rd_en;

  // role of the secondary write pin, captured while reset is held
  always_ff @(posedge rclk_i) begin
    if (!rst_ni) mode_q <= ld_i ? MODE_TWO_EN : MODE_LOAD;
  end

  assign rd_en  = !ren1_ni && !ren2_ni && empty_no && !(mode_q == MODE_LOAD && !ld_i);
  assign rbin_n = rbin_q + PW'(rd_en);
  assign wbin_s = g2b(wgray_s_i);
  assign cnt_n  = wbin_s - rbin_n;

  always_ff @(posedge rclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rbin_q          <= '0;
      rgray_q         <= '0;
      data_q          <= '0;
      empty_no        <= 1'b0;
      almost_empty_no <= 1'b0;
    end else begin
      rbin_q          <= rbin_n;
      rgray_q         <= rbin_n ^ (rbin_n >> 1);
      empty_no        <= (cnt_n != '0);
      almost_empty_no <= (cnt_n > {1'b0, ae_thr_i});
      if (rd_en) data_q <= mem_data_i;
    end
  end

  assign raddr_o = rbin_q[AW-1:0];
  assign rgray_o = rgray_q;
  assign data_o  = data_q;

  // R4
  rd_occupancy_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    (wbin_s - rbin_q) <= PW'(DEPTH));
  // R6
  empty_forces_ae_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !empty_no |-> !almost_empty_no);
  // R2
  hold_when_empty_chk: assert property (@(posedge rclk_i) disable iff (!rst_ni)
    !empty_no |=> $stable(data_o));
endmodule

// File: rtl/dc_prog_fifo.sv
module dc_prog_fifo #(
  parameter int DW = 9,
  parameter int AW = 4
) (
  input  logic          wclk_i,
  input  logic          rclk_i,
  input  logic          rst_ni,
  input  logic          wen1_ni,
  input  logic          wen2_ld_i,
  input  logic [DW-1:0] data_i,
  input  logic          ren1_ni,
  input  logic          ren2_ni,
  input  logic          oe_ni,
  input  logic [AW-1:0] ae_thr_i,
  input  logic [AW-1:0] af_thr_i,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o,
  output logic          empty_no,
  output logic          full_no,
  output logic          almost_empty_no,
  output logic          almost_full_no
);
  localparam int PW = AW + 1;

  logic          we;
  logic [AW-1:0] waddr, raddr;
  logic [PW-1:0] wgray, wgray_s, rgray, rgray_s;
  logic [DW-1:0] mem_rdata;

  dcpf_wr_ctl #(.AW(AW)) u_wr (
    .wclk_i, .rst_ni, .wen1_ni, .wen2_i(wen2_ld_i),
    .rgray_s_i(rgray_s), .af_thr_i, .we_o(we), .waddr_o(waddr),
    .wgray_o(wgray), .full_no, .almost_full_no
  );

  dcpf_sync #(.W(PW)) u_w2r (.clk_i(rclk_i), .rst_ni, .d_i(wgray), .q_o(wgray_s));
  dcpf_sync #(.W(PW)) u_r2w (.clk_i(wclk_i), .rst_ni, .d_i(rgray), .q_o(rgray_s));

  dcpf_mem #(.DW(DW), .AW(AW)) u_mem (
    .wclk_i, .we_i(we), .waddr_i(waddr), .wdata_i(data_i),
    .raddr_i(raddr), .rdata_o(mem_rdata)
  );

  dcpf_rd_ctl #(.DW(DW), .AW(AW)) u_rd (
    .rclk_i, .rst_ni, .ren1_ni, .ren2_ni, .ld_i(wen2_ld_i),
    .wgray_s_i(wgray_s), .ae_thr_i, .mem_data_i(mem_rdata),
    .raddr_o(raddr), .rgray_o(rgray), .data_o, .empty_no, .almost_empty_no
  );

  assign data_oe_o = !oe_ni;
endmodule

// File: tb/dc_prog_fifo_tb_top.sv
module dc_prog_fifo_tb_top;
  localparam int DW = 9;
  localparam int AW = 4;
  localparam int D  = 1 << AW;

  logic wclk = 0, rclk = 0, rst_n = 0;
  logic wen1 = 1, wen2 = 1, ren1 = 1, ren2 = 1, oe_n = 1;
  logic [DW-1:0] din = '0;
  logic [AW-1:0] n_thr = 4'd7, m_thr = 4'd7;
  logic [DW-1:0] dout;
  logic oe_o, ef_n, ff_n, pae_n, paf_n;

  int total = 0, bad = 0;
  logic [DW-1:0] q[$];
  logic [DW-1:0] last_rd = '0;

  always #2.5 wclk = ~wclk;
  always #3.5 rclk = ~rclk;

  dc_prog_fifo #(.DW(DW), .AW(AW)) dut_i (
    .wclk_i(wclk), .rclk_i(rclk), .rst_ni(rst_n), .wen1_ni(wen1), .wen2_ld_i(wen2),
    .data_i(din), .ren1_ni(ren1), .ren2_ni(ren2), .oe_ni(oe_n),
    .ae_thr_i(n_thr), .af_thr_i(m_thr), .data_o(dout), .data_oe_o(oe_o),
    .empty_no(ef_n), .full_no(ff_n), .almost_empty_no(pae_n), .almost_full_no(paf_n)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge rclk);
    @(negedge wclk);
  endtask

  task automatic check_flags();
    int c = q.size();
    chk("R4 empty flag", int'(ef_n), int'(c != 0));
    chk("R5 full flag", int'(ff_n), int'(c != D));
    chk("R6 almost-empty", int'(pae_n), int'(c > int'(n_thr)));
    chk("R7 almost-full", int'(paf_n), int'((D - c) > int'(m_thr)));
  endtask

  task automatic do_reset(input logic pin);
    rst_n = 0; wen1 = 1; ren1 = 1; ren2 = 1; wen2 = pin;
    repeat (4) @(negedge wclk);
    @(negedge rclk);
    rst_n = 1;
    q.delete(); last_rd = '0;
    repeat (3) @(negedge rclk);
  endtask

  // push with given secondary-pin level; model follows R1
  task automatic push(input logic [DW-1:0] d, input logic pin);
    @(negedge wclk);
    wen2 = pin; din = d; wen1 = 0;
    if (pin && ff_n) q.push_back(d);
    @(negedge wclk);
    wen1 = 1; wen2 = 1;
  endtask

  // pop; expect_pop tells the model whether the read is allowed (R3)
  task automatic pop(input bit expect_pop, input string tag);
    @(negedge rclk);
    ren1 = 0; ren2 = 0;
    if (expect_pop && q.size() > 0) last_rd = q.pop_front();
    @(negedge rclk);
    ren1 = 1; ren2 = 1;
    chk(tag, int'(dout), int'(last_rd));
  endtask

  task automatic sweep(input int n, input int m);
    n_thr = AW'(n); m_thr = AW'(m);
    for (int k = 0; k <= D; k++) begin
      settle();
      check_flags();
      push(DW'(k * 29 + n * 3 + 1), 1'b1);   // k == D is the R1 overflow attempt
    end
    settle();
    check_flags();
    for (int k = 0; k <= D; k++) begin
      pop(1'b1, "R2 pop data");                 // k == D is the R2 underflow attempt
      settle();
      check_flags();
    end
  endtask

  initial begin
    #3_000_000;
    bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R8 reset state
    do_reset(1'b1);
    chk("R8 empty", int'(ef_n), 0);
    chk("R8 almost-empty", int'(pae_n), 0);
    chk("R8 full", int'(ff_n), 1);
    chk("R8 almost-full", int'(paf_n), 1);
    chk("R8 data", int'(dout), 0);

    // R11
    oe_n = 0; #1; chk("R11 oe low", int'(oe_o), 1);
    oe_n = 1; #1; chk("R11 oe high", int'(oe_o), 0);

    // R10 first word waits for a read
    push(9'h0A5, 1'b1);
    settle();
    chk("R10 empty released", int'(ef_n), 1);
    chk("R10 data before read", int'(dout), 0);
    pop(1'b1, "R10 first word");
    settle();
    check_flags();

    // R4..R7 sweeps with several thresholds
    sweep(7, 7);
    sweep(0, 0);
    sweep(3, 12);
    sweep(15, 15);

    // R3 two-enable mode: pin low blocks writes, does not block reads
    do_reset(1'b1);
    n_thr = 4'd1; m_thr = 4'd1;
    push(9'h011, 1'b1);
    push(9'h1AA, 1'b0);
    push(9'h022, 1'b1);
    settle();
    check_flags();
    @(negedge rclk); wen2 = 0;
    pop(1'b1, "R3 two-enable read with pin low");
    wen2 = 1;
    pop(1'b1, "R3 two-enable second read");
    settle();
    chk("R3 blocked write absent", int'(ef_n), 0);

    // R3 load mode: pin low blocks reads
    do_reset(1'b0);
    wen2 = 1;
    chk("R8 load-mode reset data", int'(dout), 0);
    push(9'h033, 1'b1);
    push(9'h044, 1'b1);
    push(9'h1BB, 1'b0);
    settle();
    @(negedge rclk); wen2 = 0;
    pop(1'b0, "R3 load-mode read with pin low ignored");
    wen2 = 1;
    settle();
    check_flags();
    pop(1'b1, "R3 load-mode read first");
    pop(1'b1, "R3 load-mode read second");
    settle();
    check_flags();
    pop(1'b1, "R3 load-mode underflow hold");

    // reset with content present
    do_reset(1'b1);
    push(9'h055, 1'b1);
    push(9'h066, 1'b1);
    do_reset(1'b1);
    settle();
    chk("R8 reset clears count", int'(ef_n), 0);
    chk("R8 reset clears data", int'(dout), 0);

    // R9 streaming at unrelated clock rates
    do_reset(1'b1);
    begin
      logic [DW-1:0] sent[$];
      int got = 0;
      fork
        begin
          int i = 0;
          while (i < 60) begin
            @(negedge wclk);
            if (ff_n) begin
              din = DW'(i * 37 + 5); wen1 = 0;
              sent.push_back(DW'(i * 37 + 5));
              i++;
            end else wen1 = 1;
          end
          @(negedge wclk);
          wen1 = 1;
        end
        begin
          bit pend = 0;
          int cyc = 0;
          while (got < 60) begin
            @(negedge rclk);
            if (pend) begin
              chk("R9 stream order", int'(dout), int'(sent[got]));
              got++;
            end
            cyc++;
            if (ef_n && (cyc % 3 != 2) && got + int'(pend) < 60 && !(pend && got >= 60)) begin
              ren1 = 0; ren2 = 0; pend = 1;
            end else begin
              ren1 = 1; ren2 = 1; pend = 0;
            end
          end
          ren1 = 1; ren2 = 1;
        end
      join
    end
    settle();
    chk("R9 drained", int'(ef_n), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule